// File: doc/BRIEF.md
# Late-Write Synchronous SRAM with Zero Bus Turnaround

This block is an on-chip model of a synchronous static RAM whose read and write cycles can be interleaved freely with no idle cycle between them. Each word is 36 bits wide and is split into four 9-bit byte lanes. Address, control and byte enables are sampled on the rising clock edge. Write data follows its command by a fixed number of cycles, and read data leaves the block after the same delay. Because both delays match, a shared data bus carries a useful word on every cycle.

A static mode input selects between two timings. In the pipelined timing, write data follows its command by two cycles and read data passes through an output register. In the flow-through timing, write data follows by one cycle and read data comes straight from the array. Because write data arrives late, a read can name a word whose write has been accepted but not yet stored. Such a read returns the pending bytes merged with the stored ones.

Three chip selects must all be active for a new access. An advance input continues a four-beat burst on the two low address bits, in either linear or interleaved order. A sleep input blocks new accesses. An asynchronous output enable turns off the read drive at any time.

Top module: `latewrite_sram`

## Requirements
- R1: A new write is accepted at an edge where the block is selected, `adv`=0, `wr`=1 and `sleep`=0. Its word is stored from `wdata` as sampled at the second following edge when `flow_mode`=0, or at the first following edge when `flow_mode`=1.
- R2: With `flow_mode`=0, a read accepted at edge n drives its word on `q`, with `q_en`=1, from just after edge n+1 until edge n+2.
- R3: With `flow_mode`=1, a read accepted at edge n drives its word on `q`, with `q_en`=1, from just after edge n until edge n+1.
- R4: Reads and writes may be accepted on consecutive edges in any mix and order, with no idle cycle between them.
- R5: Byte enable `be[i]`=1 writes bits [9i+8:9i]. A lane whose enable is 0 keeps its stored value.
- R6: A new access needs `sel0_n`=0, `sel1`=1 and `sel2_n`=0. Any other combination with `adv`=0 is a deselect: nothing is written and nothing is driven.
- R7: When the previous edge accepted an access, `adv`=1 accepts the next beat of that burst. The beat keeps the burst's upper address bits and direction, and `addr`, `wr` and the selects are ignored. The low two address bits become (start+k) mod 4 when `order`=0 (linear), or start XOR k when `order`=1 (interleaved), where k counts beats mod 4. `be` is sampled on every beat.
- R8: `oe_n`=1 forces `q_en` low at once, without waiting for a clock edge.
- R9: `sleep`=1 at an edge makes that edge accept nothing and ends any burst. Writes accepted earlier still take their data and complete.
- R10: A read returns the effect of every write accepted before it. This includes a write whose data has not yet reached the array, merged lane by lane.
- R11: Synchronous active-low `rst_n` clears the pipeline and the burst state, so `q_en` is low after a reset edge. Stored words are kept.
- R12: `adv`=1 when the previous edge accepted no access is an idle cycle.
- R13: `q_en` is high only in the data cycle of an accepted read while `oe_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flow_mode | input | 1 | 1 = flow-through timing, 0 = pipelined; change only in reset |
| order | input | 1 | Burst order: 0 linear, 1 interleaved |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| adv | input | 1 | Continue the current burst |
| wr | input | 1 | 1 = write, 0 = read, for a new access |
| sleep | input | 1 | Block new accesses |
| addr | input | ADDR_W | Word address of a new access |
| be | input | LANES | Per-lane write enables |
| wdata | input | LANES*LANE_W | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| q | output | LANES*LANE_W | Read data, zero when not driven |
| q_en | output | 1 | Read data drive enable |

## Verification
The bench first fills every word, then reads every word back in a dense stream. This separates correct storage from mis-timed data capture. Next it alternates each write with an immediate read of the same word and of a different word, in both timings, and sweeps all sixteen lane-enable patterns. This tells a working forward path from a read of stale array contents. It also drives every chip-select combination, sleep cycles in the middle of pending writes, and advance cycles with and without a live burst. Finally it runs bursts of six beats from every start offset in both orders, which checks the wrap and the ignored address pins.

// File: rtl/lws_pkg.sv
// Shared definitions for the late-write SRAM: burst order type and the
// beat-offset function. Assumes a four-beat burst on the low address bits.
package lws_pkg;

    localparam int BEAT_BITS = 2;

    typedef enum logic {
        ORDER_LINEAR = 1'b0,
        ORDER_XOR    = 1'b1
    } burst_order_e;

    // Offset of beat k within a burst that started at offset start.
    function automatic logic [BEAT_BITS-1:0] beat_offset(
        input logic [BEAT_BITS-1:0] start,
        input logic [BEAT_BITS-1:0] k,
        input burst_order_e         ord
    );
        logic [BEAT_BITS-1:0] sum;
        sum = start + k;
        return (ord == ORDER_XOR) ? (start ^ k) : sum;
    endfunction

endpackage

// File: rtl/lws_burst_seq.sv
// Access acceptance and burst address generation. Decides at each edge
// whether a new access, a burst continuation or nothing is accepted, and
// presents the effective address and direction. Assumes order is steady
// during a burst.
module lws_burst_seq
    import lws_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_ok,
    input  logic              adv,
    input  logic              wr,
    input  logic              sleep,
    input  logic              order,
    input  logic [ADDR_W-1:0] addr,
    output logic              acc_valid,
    output logic              acc_wr,
    output logic [ADDR_W-1:0] acc_addr
);
    localparam int HI_W = ADDR_W - BEAT_BITS;

    logic                 active_q;
    logic                 wr_q;
    logic [HI_W-1:0]      base_q;
    logic [BEAT_BITS-1:0] start_q;
    logic [BEAT_BITS-1:0] cnt_q;
    logic [BEAT_BITS-1:0] cnt_nx;
    logic                 take_new;
    logic                 take_next;

    // Classify the current edge and form the address of the accepted beat.
    always_comb begin
        take_new  = sel_ok && !adv && !sleep;
        take_next = adv && !sleep && active_q;
        cnt_nx    = cnt_q + {{(BEAT_BITS-1){1'b0}}, 1'b1};
        acc_valid = take_new || take_next;
        acc_wr    = take_new ? wr : wr_q;
        acc_addr  = take_new ? addr
                             : {base_q, beat_offset(start_q, cnt_nx, burst_order_e'(order))};
    end

    // Track the live burst: load on a new access, step on a beat, else end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            wr_q     <= 1'b0;
            base_q   <= '0;
            start_q  <= '0;
            cnt_q    <= '0;
        end else if (take_new) begin
            active_q <= 1'b1;
            wr_q     <= wr;
            base_q   <= addr[ADDR_W-1:BEAT_BITS];
            start_q  <= addr[BEAT_BITS-1:0];
            cnt_q    <= '0;
        end else if (take_next) begin
            cnt_q    <= cnt_nx;
        end else begin
            active_q <= 1'b0;
        end
    end

endmodule

// File: rtl/lws_lane_mem.sv
// Storage array built as one column per byte lane, each with its own
// write enable. One synchronous write port, one combinational read port.
// Assumes no reset of contents is needed.
module lws_lane_mem #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES-1:0]        wbe,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        // Store this lane when the port writes and its enable is set.
        always_ff @(posedge clk) begin
            if (we && wbe[g]) begin
                cells[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
    end

endmodule

// File: rtl/lws_pipe.sv
// Command pipeline for late writes. Stage 1 holds the accepted command,
// stage 2 holds a write waiting for pipelined data. Selects which stage
// commits with the data on the pins, and forwards pending write lanes
// into a read of the same word. Assumes flow is static outside reset.
module lws_pipe #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flow,
    input  logic                    acc_valid,
    input  logic                    acc_wr,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [LANES-1:0]        acc_be,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [LANES*LANE_W-1:0] mem_rdata,
    output logic                    rd_req,
    output logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic                    cm_en,
    output logic [ADDR_W-1:0]       cm_addr,
    output logic [LANES-1:0]        cm_be
);
    logic              s1_v, s1_wr;
    logic [ADDR_W-1:0] s1_addr;
    logic [LANES-1:0]  s1_be;
    logic              s2_v;
    logic [ADDR_W-1:0] s2_addr;
    logic [LANES-1:0]  s2_be;
    logic              fwd_hit;

    // Stage 1: capture the accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v    <= 1'b0;
            s1_wr   <= 1'b0;
            s1_addr <= '0;
            s1_be   <= '0;
        end else begin
            s1_v    <= acc_valid;
            s1_wr   <= acc_wr;
            s1_addr <= acc_addr;
            s1_be   <= acc_be;
        end
    end

    // Stage 2: hold a write one more cycle in pipelined timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_v    <= 1'b0;
            s2_addr <= '0;
            s2_be   <= '0;
        end else begin
            s2_v    <= !flow && s1_v && s1_wr;
            s2_addr <= s1_addr;
            s2_be   <= s1_be;
        end
    end

    // Commit port and read request selection.
    always_comb begin
        cm_en   = flow ? (s1_v && s1_wr) : s2_v;
        cm_addr = flow ? s1_addr : s2_addr;
        cm_be   = flow ? s1_be : s2_be;
        rd_req  = s1_v && !s1_wr;
        rd_addr = s1_addr;
        fwd_hit = !flow && s2_v && (s2_addr == s1_addr);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_fwd
        assign rd_data[g*LANE_W +: LANE_W] = (fwd_hit && s2_be[g])
                                           ? wdata[g*LANE_W +: LANE_W]
                                           : mem_rdata[g*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/lws_out_stage.sv
// Read data output: registered in pipelined timing, passed through in
// flow-through timing, gated asynchronously by the output enable.
module lws_out_stage #(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flow,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              oe_n,
    output logic [DATA_W-1:0] q,
    output logic              q_en
);
    logic              oreg_v;
    logic [DATA_W-1:0] oreg_d;
    logic              data_v;
    logic [DATA_W-1:0] data_w;

    // Output register for the pipelined timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oreg_v <= 1'b0;
            oreg_d <= '0;
        end else begin
            oreg_v <= rd_req;
            oreg_d <= rd_data;
        end
    end

    // Pick the timing's data source and apply the output enable.
    always_comb begin
        data_v = flow ? rd_req : oreg_v;
        data_w = flow ? rd_data : oreg_d;
        q_en   = data_v && !oe_n;
        q      = data_v ? data_w : '0;
    end

endmodule

// File: rtl/latewrite_sram.sv
// Top of the zero-turnaround late-write SRAM. Joins acceptance and burst
// logic, the late-write pipeline, the lane array and the output stage.
// Assumes flow_mode changes only while rst_n is low.
module latewrite_sram
    import lws_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flow_mode,
    input  logic                    order,
    input  logic                    sel0_n,
    input  logic                    sel1,
    input  logic                    sel2_n,
    input  logic                    adv,
    input  logic                    wr,
    input  logic                    sleep,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        be,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    oe_n,
    output logic [LANES*LANE_W-1:0] q,
    output logic                    q_en
);
    localparam int DATA_W = LANES * LANE_W;

    logic              sel_ok;
    logic              acc_valid, acc_wr;
    logic [ADDR_W-1:0] acc_addr;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data, mem_rdata;
    logic              cm_en;
    logic [ADDR_W-1:0] cm_addr;
    logic [LANES-1:0]  cm_be;

    assign sel_ok = !sel0_n && sel1 && !sel2_n;

    lws_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .sel_ok(sel_ok), .adv(adv), .wr(wr),
        .sleep(sleep), .order(order), .addr(addr),
        .acc_valid(acc_valid), .acc_wr(acc_wr), .acc_addr(acc_addr)
    );

    lws_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_pipe (
        .clk(clk), .rst_n(rst_n), .flow(flow_mode),
        .acc_valid(acc_valid), .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_be(be),
        .wdata(wdata), .mem_rdata(mem_rdata),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
        .cm_en(cm_en), .cm_addr(cm_addr), .cm_be(cm_be)
    );

    lws_lane_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk(clk), .we(cm_en), .waddr(cm_addr), .wbe(cm_be), .wdata(wdata),
        .raddr(rd_addr), .rdata(mem_rdata)
    );

    lws_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .flow(flow_mode), .rd_req(rd_req),
        .rd_data(rd_data), .oe_n(oe_n), .q(q), .q_en(q_en)
    );

endmodule

// File: rtl/latewrite_sram_chk.sv
// Port-level timing checks for latewrite_sram, attached by bind.
module latewrite_sram_chk (
    input logic clk,
    input logic rst_n,
    input logic flow_mode,
    input logic sel0_n,
    input logic sel1,
    input logic sel2_n,
    input logic adv,
    input logic wr,
    input logic sleep,
    input logic oe_n,
    input logic q_en
);
    logic sel_in;
    assign sel_in = !sel0_n && sel1 && !sel2_n;

    // R2: pipelined read drives one cycle after the following edge
    a_r2_pipe_read_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_mode && sel_in && !adv && !wr && !sleep) |=> ##1 (q_en == !oe_n));

    // R3: flow-through read drives right after its own edge
    a_r3_flow_read_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_mode && sel_in && !adv && !wr && !sleep) |=> (q_en == !oe_n));

    // R6: a deselect edge produces no drive
    a_r6_deselect_flow: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_mode && !sel_in && !adv) |=> !q_en);
    a_r6_deselect_pipe: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_mode && !sel_in && !adv) |=> ##1 !q_en);

    // R8: output enable high means no drive
    a_r8_oe_float: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !q_en);

    // R9: a sleeping edge produces no drive
    a_r9_sleep_flow: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_mode && sleep) |=> !q_en);
    a_r9_sleep_pipe: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_mode && sleep) |=> ##1 !q_en);

    // R11: output idle after a reset edge
    a_r11_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !q_en);

endmodule

bind latewrite_sram latewrite_sram_chk u_chk (
    .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .sel0_n(sel0_n),
    .sel1(sel1), .sel2_n(sel2_n), .adv(adv), .wr(wr), .sleep(sleep),
    .oe_n(oe_n), .q_en(q_en)
);

// File: tb/latewrite_sram_test.sv
module latewrite_sram_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flow_mode = 1'b0;
    logic        order = 1'b0;
    logic        sel0_n = 1'b1, sel1 = 1'b0, sel2_n = 1'b1;
    logic        adv = 1'b0, wr = 1'b0, sleep = 1'b0, oe_n = 1'b0;
    logic [5:0]  addr = '0;
    logic [3:0]  be = '0;
    logic [35:0] wdata = '0;
    logic [35:0] q;
    logic        q_en;

    latewrite_sram uut (
        .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .order(order),
        .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n), .adv(adv), .wr(wr),
        .sleep(sleep), .addr(addr), .be(be), .wdata(wdata), .oe_n(oe_n),
        .q(q), .q_en(q_en)
    );

    always #4 clk = ~clk;

    int          vectors = 0;
    int          miscompares = 0;
    int          cyc = 0;
    bit          done = 0;
    bit          probe_oe = 0;
    logic [35:0] ref_mem [64];
    logic [35:0] wd_q [4];
    logic        exp_v [4];
    logic [35:0] exp_d [4];
    string       exp_req [4];
    logic        b_active = 0, b_wr = 0;
    logic [5:0]  b_base = '0;
    logic [1:0]  b_start = '0, b_cnt = '0;

    function automatic logic [35:0] pat(input int a, input int s);
        return (36'(a) * 36'h0_0F1E_2D3C) ^ (36'(s) << 20) ^ 36'h5_A5A5_A5A5;
    endfunction

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One clock slot: check the outputs due now, then drive this slot.
    task automatic slot(input logic c0, input logic c1, input logic c2, input logic c_adv,
                        input logic c_wr, input logic c_sleep, input logic [5:0] c_addr,
                        input logic [3:0] c_be, input logic [35:0] c_d, input string req);
        int s;
        int lat;
        logic acc, w;
        logic [5:0] a;
        @(negedge clk);
        s = cyc % 4;
        if (exp_v[s]) begin
            if (probe_oe) begin
                oe_n = 1'b1; #1;
                check("R8 oe float", 36'(q_en), 36'd0);
                oe_n = 1'b0; #1;
            end
            check({exp_req[s], " drive"}, 36'(q_en), 36'd1);
            check(exp_req[s], q, exp_d[s]);
        end else begin
            check("R13 idle drive", 36'(q_en), 36'd0);
        end
        exp_v[s] = 1'b0;
        sel0_n = c0; sel1 = c1; sel2_n = c2; adv = c_adv; wr = c_wr;
        sleep = c_sleep; addr = c_addr; be = c_be; wdata = wd_q[s];
        wd_q[s] = pat(cyc, 77);
        lat = flow_mode ? 1 : 2;
        acc = 1'b0; w = 1'b0; a = c_addr;
        if (c_sleep) begin
            b_active = 1'b0;
        end else if (c_adv) begin
            if (b_active) begin
                b_cnt = b_cnt + 2'd1;
                a = {b_base[5:2], order ? (b_start ^ b_cnt) : 2'(b_start + b_cnt)};
                acc = 1'b1; w = b_wr;
            end
        end else if (!c0 && c1 && !c2) begin
            acc = 1'b1; w = c_wr; b_active = 1'b1; b_base = c_addr;
            b_start = c_addr[1:0]; b_cnt = 2'd0; b_wr = c_wr;
        end else begin
            b_active = 1'b0;
        end
        if (acc && w) begin
            for (int i = 0; i < 4; i++)
                if (c_be[i]) ref_mem[a][i*9 +: 9] = c_d[i*9 +: 9];
            wd_q[(cyc + lat) % 4] = c_d;
        end else if (acc) begin
            exp_v[(cyc + lat) % 4]   = 1'b1;
            exp_d[(cyc + lat) % 4]   = ref_mem[a];
            exp_req[(cyc + lat) % 4] = req;
        end
        cyc++;
    endtask

    task automatic wr_op(input logic [5:0] a, input logic [3:0] m, input logic [35:0] d, input string req);
        slot(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, a, m, d, req);
    endtask
    task automatic rd_op(input logic [5:0] a, input string req);
        slot(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, a, 4'hF, 36'd0, req);
    endtask
    task automatic idle();
        slot(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'($urandom), 4'hF, 36'd0, "R13");
    endtask
    task automatic beat(input logic [3:0] m, input logic [35:0] d, input string req);
        slot(1'b1, 1'b0, 1'b1, 1'b1, 1'($urandom), 1'b0, 6'($urandom), m, d, req);
    endtask

    task automatic do_reset(input logic fm);
        repeat (3) idle();
        @(negedge clk);
        rst_n = 1'b0; flow_mode = fm;
        sel0_n = 1'b1; sel1 = 1'b0; sel2_n = 1'b1; adv = 1'b0; sleep = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 4; i++) begin exp_v[i] = 1'b0; wd_q[i] = '0; end
        b_active = 1'b0;
        check("R11 reset drive", 36'(q_en), 36'd0);
        rst_n = 1'b1;
    endtask

    task automatic suite(input int seed);
        // R1 R2 R3: fill every word, then stream reads
        for (int a = 0; a < 64; a++) wr_op(6'(a), 4'hF, pat(a, seed), "R1");
        for (int a = 0; a < 64; a++) rd_op(6'(a), flow_mode ? "R3 read" : "R2 read");
        // R4 R10: write then immediate reads of same and other words
        for (int a = 0; a < 32; a++) begin
            wr_op(6'(a * 2), 4'hF, pat(a, seed + 1), "R4");
            rd_op(6'(a * 2), "R10 raw");
            rd_op(6'(a * 2 + 5), "R4 mix");
        end
        // R5: every lane-enable pattern, read right after
        for (int m = 0; m < 16; m++) begin
            wr_op(6'd7, 4'(m), pat(m, seed + 2), "R5");
            rd_op(6'd7, "R5 lanes");
        end
        // R6: every select combination
        for (int c = 0; c < 8; c++) begin
            slot(c[0], c[1], c[2], 1'b0, 1'b1, 1'b0, 6'd9, 4'hF, pat(c, seed + 3), "R6");
            rd_op(6'd9, "R6 select");
            slot(c[0], c[1], c[2], 1'b0, 1'b0, 1'b0, 6'd9, 4'hF, 36'd0, "R6 read");
        end
        // R9: sleeping write ignored, earlier write completes
        wr_op(6'd5, 4'hF, pat(5, seed + 4), "R9");
        slot(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd3, 4'hF, pat(3, 999), "R9");
        slot(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 6'd3, 4'hF, 36'd0, "R9");
        rd_op(6'd3, "R9 ignored");
        rd_op(6'd5, "R9 completes");
        // R12: advance with no live burst, and after sleep
        idle();
        beat(4'hF, pat(1, 1), "R12");
        rd_op(6'd20, "R7");
        slot(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 6'd0, 4'hF, 36'd0, "R9");
        beat(4'hF, pat(2, 2), "R12");
        // R7: bursts in both orders from every start offset
        for (int o = 0; o < 2; o++) begin
            for (int st = 0; st < 4; st++) begin
                idle();
                order = 1'(o);
                wr_op({4'(8 + o * 4 + st), 2'(st)}, 4'hF, pat(st, seed + 10 + o), "R7");
                for (int k = 1; k < 4; k++) beat(4'hF, pat(st * 4 + k, seed + 20 + o), "R7");
                rd_op({4'(8 + o * 4 + st), 2'(st)}, "R7 burst");
                for (int k = 1; k < 6; k++) beat(4'hF, 36'd0, "R7 burst");
            end
        end
        // R8: output enable probed on a few reads
        probe_oe = 1;
        for (int a = 0; a < 4; a++) rd_op(6'(a), "R8 read");
        repeat (3) idle();
        probe_oe = 0;
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin exp_v[i] = 1'b0; wd_q[i] = '0; exp_d[i] = '0; end
        for (int i = 0; i < 64; i++) ref_mem[i] = '0;
        do_reset(1'b0);
        suite(1);
        do_reset(1'b1);
        for (int a = 0; a < 8; a++) rd_op(6'(a), "R11 kept");
        suite(50);
        repeat (4) idle();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule